// File: doc/BRIEF.md
# Keyed Quadrature Numerically Controlled Oscillator

This block is a numerically controlled oscillator that produces digital sample words for an external D/A converter. A 32-bit phase register advances on every sample clock by a frequency step. The upper phase bits, after an optional phase offset is added, select an amplitude from internal constant logic. The output frequency is `step * fclk / 2^32`, so the frequency resolution is `fclk / 2^32`.

Three keying controls act at three different points. Frequency keying picks one of two step words before the adder. Phase keying adds a quarter-cycle multiple to the table address. Amplitude keying scales each sample by an 8-bit gain. A shape select chooses sine, triangle, sawtooth or rectangle. Two channels read the same phase register a quarter cycle apart, which gives an in-phase output and a quadrature output. Changing the step never clears the phase, so the waveform stays continuous across a frequency change.

Top module: `nco_keyed_top`

## Requirements
- R1: On each rising clock edge outside reset, the phase register becomes its old value plus `freq_word_b` when `freq_sel` is 1, or plus `freq_word_a` when it is 0, modulo 2^32. A change of selection or word takes effect at the next edge and never clears the phase.
- R2: While `rst` is high at a rising edge, the phase register, both lookup registers and both outputs are cleared to 0, so both outputs read 0 after that edge.
- R3: The table address is the top 10 phase bits plus `256 * phase_key`, modulo 1024. `phase_key` values 0, 1, 2 and 3 give shifts of 0, 90, 180 and 270 degrees.
- R4: With `wave_sel` = 0 (sine), for address a with h = a mod 512, the magnitude is floor(2047 * 16h(512-h) / (5 * 512^2 - 4h(512-h))). It is positive for a < 512 and negative otherwise.
- R5: With `wave_sel` = 1 (triangle), with h = a mod 512 and t = h when h <= 256 or 512-h otherwise, the magnitude is floor(2047 * t / 256). It is positive for a < 512 and negative otherwise.
- R6: With `wave_sel` = 2 (sawtooth), the sample is 4 * (a - 512), ramping from -2048 to 2044.
- R7: With `wave_sel` = 3 (rectangle), the sample is +2047 for a < 512 and -2047 otherwise. At full gain the outputs are therefore 2039 or -2040.
- R8: `cos_out` uses the same shape as `sin_out`, evaluated at address (a + 256) mod 1024.
- R9: The output is floor(sample * gain / 256), with `gain` unsigned. A gain of 0 gives 0 on both outputs.
- R10: The output after edge t+2 is computed from the phase, `phase_key` and `wave_sel` present before edge t+1, and from the `gain` present before edge t+2. This is a fixed latency of two clocks.
- R11: With a constant step K that divides 2^32, the output sequence repeats every 2^32/K clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word_a | input | 32 | Phase step used when `freq_sel` is 0 |
| freq_word_b | input | 32 | Phase step used when `freq_sel` is 1 |
| freq_sel | input | 1 | Frequency key: selects the step word |
| phase_key | input | 2 | Phase key: quarter-cycle offset count |
| gain | input | 8 | Amplitude key: unsigned gain, full scale 256 |
| wave_sel | input | 2 | Shape: 0 sine, 1 triangle, 2 sawtooth, 3 rectangle |
| sin_out | output | 12 | In-phase sample, two's complement |
| cos_out | output | 12 | Quadrature sample, two's complement |

## Verification
An error in the phase register is never corrected by later cycles. It shows as a lasting phase shift on both outputs, visible two clocks after the faulty addition, and it repeats in every later period. A wrong lookup or scaling value affects only the sample that carries it, so the bench compares both outputs with a behavioural model on every clock. It also checks the two-clock latency and the repeat period directly.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Shape selection codes; the numeric values are part of the port contract.
  typedef enum logic [1:0] {
    WAVE_SINE = 2'd0,
    WAVE_TRI  = 2'd1,
    WAVE_SAW  = 2'd2,
    WAVE_RECT = 2'd3
  } wave_e;

  // Rational sine approximation over one half cycle of `half` steps,
  // evaluated at position idx, scaled to `peak`. Exact zero at the ends
  // and exact peak at the centre.
  function automatic int sine_fold_mag(input int idx, input int half, input int peak);
    longint prod;
    longint num;
    longint den;
    prod = longint'(idx) * longint'(half - idx);
    num  = 64'sd16 * longint'(peak) * prod;
    den  = 64'sd5 * longint'(half) * longint'(half) - 64'sd4 * prod;
    return int'(num / den);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASE_W-1:0] word_a,
  input  logic [PHASE_W-1:0] word_b,
  input  logic              word_sel,
  input  logic [1:0]        phase_key,
  output logic [ADDR_W-1:0] phase_addr
);
  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] step;
  logic [PHASE_W-1:0] acc_next;
  logic [ADDR_W-1:0]  key_offset;

  // Frequency keying acts on the increment only; the phase is never cleared.
  always_comb step = word_sel ? word_b : word_a;
  assign acc_next = acc_q + step;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_next;
  end

  // Phase keying adds a quarter-cycle multiple to the truncated phase.
  assign key_offset = {phase_key, {(ADDR_W-2){1'b0}}};
  assign phase_addr = acc_q[PHASE_W-1 -: ADDR_W] + key_offset;
endmodule

// File: rtl/nco_shaper.sv
module nco_shaper
  import nco_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 12
) (
  input  logic                    [ADDR_W-1:0] addr,
  input  wave_e                                shape,
  output logic signed             [AMP_W-1:0]  sample
);
  localparam int QUARTER = 1 << (ADDR_W - 2);
  localparam int HALF    = 2 * QUARTER;
  localparam int PEAK    = (1 << (AMP_W - 1)) - 1;
  localparam int MAG_W   = AMP_W - 1;
  localparam int IDX_W   = ADDR_W - 1;
  localparam int TRI_W   = IDX_W + MAG_W;
  localparam logic signed [AMP_W-1:0] PEAK_S = AMP_W'(PEAK);

  // Quarter-wave magnitude table, QUARTER+1 entries, built from constant logic.
  logic [MAG_W-1:0] qrom [QUARTER+1];
  for (genvar g = 0; g <= QUARTER; g++) begin : g_qrom
    assign qrom[g] = MAG_W'(sine_fold_mag(g, HALF, PEAK));
  end

  logic              neg_half;
  logic [ADDR_W-1:0] half_pos;
  logic [ADDR_W-1:0] fold_full;
  logic [IDX_W-1:0]  fold_idx;
  logic [MAG_W-1:0]  sine_mag;
  logic [TRI_W-1:0]  tri_prod;
  logic [MAG_W-1:0]  tri_mag;

  // Mirror the second quarter of each half onto the first.
  assign neg_half  = addr[ADDR_W-1];
  assign half_pos  = {1'b0, addr[ADDR_W-2:0]};
  assign fold_full = addr[ADDR_W-2] ? (ADDR_W'(HALF) - half_pos) : half_pos;
  assign fold_idx  = IDX_W'(fold_full);
  assign sine_mag  = qrom[fold_idx];

  // Triangle shares the fold; linear scale of the folded index.
  assign tri_prod = {{MAG_W{1'b0}}, fold_idx} * TRI_W'(PEAK);
  assign tri_mag  = MAG_W'(tri_prod >> (ADDR_W - 2));

  always_comb begin
    unique case (shape)
      WAVE_SINE: sample = neg_half ? -$signed({1'b0, sine_mag}) : $signed({1'b0, sine_mag});
      WAVE_TRI:  sample = neg_half ? -$signed({1'b0, tri_mag})  : $signed({1'b0, tri_mag});
      WAVE_SAW:  sample = {~addr[ADDR_W-1], addr[ADDR_W-2:0], {(AMP_W-ADDR_W){1'b0}}};
      WAVE_RECT: sample = neg_half ? -PEAK_S : PEAK_S;
      default:   sample = '0;
    endcase
  end
endmodule

// File: rtl/nco_gain_stage.sv
module nco_gain_stage #(
  parameter int AMP_W  = 12,
  parameter int GAIN_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [AMP_W-1:0] sample_in,
  input  logic        [GAIN_W-1:0] gain,
  output logic signed [AMP_W-1:0] out_q
);
  localparam int PROD_W = AMP_W + GAIN_W + 1;

  logic signed [PROD_W-1:0] samp_ext;
  logic signed [PROD_W-1:0] gain_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [AMP_W-1:0]  scaled;

  assign samp_ext = PROD_W'(sample_in);
  assign gain_ext = $signed(PROD_W'({1'b0, gain}));
  assign prod     = samp_ext * gain_ext;
  // Arithmetic shift floors toward minus infinity.
  assign scaled   = AMP_W'(prod >>> GAIN_W);

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= scaled;
  end
endmodule

// File: rtl/nco_keyed_top.sv
module nco_keyed_top
  import nco_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10,
  parameter int AMP_W   = 12,
  parameter int GAIN_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PHASE_W-1:0]       freq_word_a,
  input  logic [PHASE_W-1:0]       freq_word_b,
  input  logic                     freq_sel,
  input  logic [1:0]               phase_key,
  input  logic [GAIN_W-1:0]        gain,
  input  logic [1:0]               wave_sel,
  output logic signed [AMP_W-1:0]  sin_out,
  output logic signed [AMP_W-1:0]  cos_out
);
  localparam int QUARTER = 1 << (ADDR_W - 2);
  localparam int N_CH    = 2;

  logic [ADDR_W-1:0]            phase_addr;
  wave_e                        shape_sel;
  logic [N_CH-1:0][AMP_W-1:0]   chan_out;

  assign shape_sel = wave_e'(wave_sel);

  nco_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
    .clk        (clk),
    .rst        (rst),
    .word_a     (freq_word_a),
    .word_b     (freq_word_b),
    .word_sel   (freq_sel),
    .phase_key  (phase_key),
    .phase_addr (phase_addr)
  );

  // Channel 0 in phase, channel 1 a quarter cycle ahead, same accumulator.
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    logic [ADDR_W-1:0]       ch_addr;
    logic signed [AMP_W-1:0] shape_now;
    logic signed [AMP_W-1:0] shape_q;
    logic signed [AMP_W-1:0] scaled_q;

    assign ch_addr = phase_addr + ADDR_W'(ch * QUARTER);

    nco_shaper #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_shape (
      .addr   (ch_addr),
      .shape  (shape_sel),
      .sample (shape_now)
    );

    always_ff @(posedge clk) begin
      if (rst) shape_q <= '0;
      else     shape_q <= shape_now;
    end

    nco_gain_stage #(.AMP_W(AMP_W), .GAIN_W(GAIN_W)) u_gain (
      .clk       (clk),
      .rst       (rst),
      .sample_in (shape_q),
      .gain      (gain),
      .out_q     (scaled_q)
    );

    assign chan_out[ch] = scaled_q;
  end

  assign sin_out = $signed(chan_out[0]);
  assign cos_out = $signed(chan_out[1]);
endmodule

// File: rtl/nco_keyed_chk.sv
module nco_keyed_chk #(
  parameter int PHASE_W = 32,
  parameter int AMP_W   = 12,
  parameter int GAIN_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [PHASE_W-1:0]      freq_word_a,
  input logic [PHASE_W-1:0]      freq_word_b,
  input logic                    freq_sel,
  input logic [GAIN_W-1:0]       gain,
  input logic [1:0]              wave_sel,
  input logic signed [AMP_W-1:0] sin_out,
  input logic signed [AMP_W-1:0] cos_out,
  input logic [PHASE_W-1:0]      acc_q
);
  localparam int PEAK    = (1 << (AMP_W - 1)) - 1;
  localparam int GMAX    = (1 << GAIN_W) - 1;
  localparam int DIV     = 1 << GAIN_W;
  localparam int RECT_HI = (PEAK * GMAX) / DIV;
  localparam int RECT_LO = -((PEAK * GMAX + DIV - 1) / DIV);

  // Clean cycles since reset, saturating at 3.
  logic [1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst)               run_cnt <= 2'd0;
    else if (run_cnt != 3) run_cnt <= run_cnt + 2'd1;
  end

  AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 2'd1) |-> (acc_q == $past(acc_q) + ($past(freq_sel) ? $past(freq_word_b) : $past(freq_word_a)))); // R1

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && sin_out == '0 && cos_out == '0)); // R2

  AST_GAIN_MUTE: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 2'd1 && $past(gain) == '0) |-> (sin_out == '0 && cos_out == '0)); // R9

  AST_RECT_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 2'd2 && $past(wave_sel, 2) == 2'd3 && $past(gain) == GAIN_W'(GMAX))
    |-> ((int'(sin_out) == RECT_HI || int'(sin_out) == RECT_LO) &&
         (int'(cos_out) == RECT_HI || int'(cos_out) == RECT_LO))); // R7
endmodule

bind nco_keyed_top nco_keyed_chk #(
  .PHASE_W(PHASE_W), .AMP_W(AMP_W), .GAIN_W(GAIN_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .freq_word_a (freq_word_a),
  .freq_word_b (freq_word_b),
  .freq_sel    (freq_sel),
  .gain        (gain),
  .wave_sel    (wave_sel),
  .sin_out     (sin_out),
  .cos_out     (cos_out),
  .acc_q       (u_acc.acc_q)
);

// File: tb/nco_keyed_top_tb_top.sv
module nco_keyed_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fw_a = '0;
  logic [31:0] fw_b = '0;
  logic        fsel = 1'b0;
  logic [1:0]  pkey = '0;
  logic [1:0]  wsel = '0;
  logic [7:0]  gain = '0;
  logic signed [11:0] sin_o;
  logic signed [11:0] cos_o;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R2";
  bit    model_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_keyed_top dut_i (
    .clk(clk), .rst(rst), .freq_word_a(fw_a), .freq_word_b(fw_b),
    .freq_sel(fsel), .phase_key(pkey), .gain(gain), .wave_sel(wsel),
    .sin_out(sin_o), .cos_out(cos_o)
  );

  // Shape value straight from the requirement formulas (no folding).
  function automatic int shape_ref(input int a, input int sel);
    int  h;
    int  t;
    longint p;
    int  mag;
    h = a % 512;
    case (sel)
      0: begin
        p = longint'(h) * longint'(512 - h);
        mag = int'((2047 * 16 * p) / (5 * 512 * 512 - 4 * p));
        return (a < 512) ? mag : -mag;
      end
      1: begin
        t = (h <= 256) ? h : 512 - h;
        mag = (2047 * t) / 256;
        return (a < 512) ? mag : -mag;
      end
      2: return 4 * (a - 512);
      default: return (a < 512) ? 2047 : -2047;
    endcase
  endfunction

  function automatic int scale_ref(input int s, input int g);
    int p;
    p = s * g;
    if (p >= 0) return p / 256;
    return -((-p + 255) / 256);
  endfunction

  // Behavioural model, advanced on every rising edge.
  longint m_acc = 0;
  int     m_s1 [2] = '{0, 0};
  int     m_o  [2] = '{0, 0};

  always @(posedge clk) begin
    int a0;
    if (rst) begin
      m_acc = 0;
      m_s1  = '{0, 0};
      m_o   = '{0, 0};
    end else begin
      m_o[0] = scale_ref(m_s1[0], int'(gain));
      m_o[1] = scale_ref(m_s1[1], int'(gain));
      a0 = int'(((m_acc >> 22) + longint'(pkey) * 256) % 1024);
      m_s1[0] = shape_ref(a0, int'(wsel));
      m_s1[1] = shape_ref((a0 + 256) % 1024, int'(wsel));
      m_acc = (m_acc + (fsel ? longint'(fw_b) : longint'(fw_a))) % (64'sd1 <<< 32);
    end
    model_on = 1'b1;
  end

  task automatic check(input logic signed [11:0] act, input int exp, input string what);
    n_chk++;
    if (act !== 12'(exp)) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      check(sin_o, m_o[0], "sin_out vs model");
      check(cos_o, m_o[1], "cos_out vs model");
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hist[$];
    // R2: reset state
    tag = "R2";
    run(3);
    check(sin_o, 0, "R2 reset sin");
    check(cos_o, 0, "R2 reset cos");

    // R10: quarter-cycle step, full gain, two-clock latency
    tag = "R10";
    fw_a = 32'h4000_0000; gain = 8'd255; wsel = 2'd0; pkey = 2'd0;
    rst = 1'b0;
    run(1);
    check(sin_o, 0, "R10 edge1 sin");
    check(cos_o, 0, "R10 edge1 cos");
    run(1);
    check(sin_o, 0, "R10 edge2 sin");
    check(cos_o, 2039, "R10 edge2 cos");
    run(1);
    check(sin_o, 2039, "R10 edge3 sin");
    check(cos_o, 0, "R10 edge3 cos");

    // R4 R8: every address of the sine, both channels
    tag = "R4 R8";
    fw_a = 32'h0040_0000;
    run(1100);
    tag = "R5"; wsel = 2'd1; run(1030);
    tag = "R6"; wsel = 2'd2; run(1030);
    tag = "R7"; wsel = 2'd3; run(1030);

    // R3: phase keying while running
    tag = "R3"; wsel = 2'd0;
    for (int k = 0; k < 8; k++) begin
      pkey = 2'(k);
      run(37);
    end

    // R1: frequency keying, continuity across switches
    tag = "R1"; pkey = 2'd0;
    fw_a = 32'h0100_0000; fw_b = 32'h0180_0000;
    for (int i = 0; i < 20; i++) begin
      fsel = i[0];
      run(13 + i);
    end
    for (int i = 0; i < 30; i++) begin
      fw_a = $urandom; fw_b = $urandom; fsel = i[1];
      wsel = 2'(i);
      run(7);
    end

    // R9: amplitude keying
    tag = "R9"; wsel = 2'd0; fw_a = 32'h0123_4567; fsel = 1'b0;
    for (int i = 0; i < 300; i++) begin
      gain = 8'($urandom);
      run(1);
    end
    gain = 8'd0;
    run(3);
    check(sin_o, 0, "R9 zero gain sin");
    check(cos_o, 0, "R9 zero gain cos");
    gain = 8'd1;
    run(50);

    // R11: repeat period 2^32/K with K = 2^24 -> 256 clocks
    tag = "R11";
    fw_a = 32'h0100_0000; gain = 8'd255; wsel = 2'd0; pkey = 2'd0;
    run(3);
    for (int i = 0; i < 256; i++) begin
      run(1);
      hist.push_back(int'(sin_o));
    end
    for (int i = 0; i < 256; i++) begin
      run(1);
      check(sin_o, hist[i], "R11 period repeat");
    end

    // R2: reset in mid run
    tag = "R2";
    rst = 1'b1;
    run(1);
    check(sin_o, 0, "R2 mid reset sin");
    check(cos_o, 0, "R2 mid reset cos");
    rst = 1'b0;
    run(20);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule